// File: doc/BRIEF.md
# PCM Sample Packing Receive FIFO

This block sits behind a pair of decimation channels and turns their 16-bit PCM samples into 32-bit words held in a small receive FIFO. On each frame strobe both channel samples are presented together. The block keeps one channel, the other, or both, depending on the capture mode. It either stores each sample sign-extended in a word of its own or packs two samples into one word. The order of the two halves depends on the mode and on a left/right swap control.

Software reaches the FIFO through a simple strobed register port. It can pop the data word, read the fill count, empty the FIFO with a flush write and program a fill threshold. There are three interrupt sources: threshold crossing, overflow and underflow. Each source has an enable bit, a raw status bit, a write-one-to-set register and a write-one-to-clear register. Register map (reg_addr_i): 0 data (read pops), 1 fill count, 2 flush, 3 threshold, 4 interrupt enable, 5 raw status, 6 set, 7 clear. Interrupt bit positions: 0 threshold, 1 overflow, 2 underflow.

Top module: `pcm_pack_fifo`

## Requirements
- R1: After reset, the fill count, threshold, interrupt enable and raw status all read 0, and irq_o is low.
- R2: chan_sel_i encodes the capture mode: 0 keeps left, 1 keeps right, 2 or 3 keeps both. In a packed mono mode, the first sample of a pair is held back. The next sample then completes a word with the newer sample in bits 31:16 and the older sample in bits 15:0.
- R3: In packed stereo mode, each frame gives one word with left in bits 31:16 and right in bits 15:0. With swap_i high, right is in 31:16 and left in 15:0.
- R4: With pack_i low, every kept sample becomes its own word, sign-extended to 32 bits. In stereo mode a frame gives two words in FIFO order: left then right, or right then left when swap_i is high. Swap has no effect in mono modes.
- R5: Register 1 reads the number of words in the FIFO. Register 0 shows the oldest word combinationally. A read strobe on register 0 pops that word, and the count drops at the same clock edge.
- R6: A write of any value to register 2 empties the FIFO and drops a held half-word. A frame arriving in the same cycle is discarded.
- R7: Status bit 0 sets on each edge where the fill count before that edge is strictly greater than the threshold. It does not set when the two are equal.
- R8: Free space is DEPTH minus the fill count before the edge, and a pop at the same edge does not add to it. Words beyond the free space are discarded, and status bit 1 sets.
- R9: A data read while the FIFO is empty returns 0, changes nothing in the FIFO and sets status bit 2.
- R10: Writing register 6 sets, and writing register 7 clears, the status bits at the 1 positions of the written value. A hardware event in the same cycle wins over a clear. irq_o is high while any status bit and its enable bit (register 4) are both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| frame_valid_i | input | 1 | One frame of samples present this cycle |
| left_i | input | SAMPLE_W (16) | Left channel sample |
| right_i | input | SAMPLE_W (16) | Right channel sample |
| chan_sel_i | input | 2 | Capture mode: 0 left, 1 right, 2/3 stereo |
| swap_i | input | 1 | Exchange left and right order in stereo |
| pack_i | input | 1 | Two samples per word when high |
| reg_we_i | input | 1 | Register write strobe |
| reg_re_i | input | 1 | Register read strobe (pops on data address) |
| reg_addr_i | input | 3 | Register address |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data, combinational |
| irq_o | output | 1 | Interrupt request |

## Verification
The bound checker watches on every cycle that the fill count stays within the depth and that a flush leaves the FIFO empty. It also checks that an empty-FIFO read, a discarded overflow word and a count above the threshold each raise their status bit on the next edge, and that a lone pop lowers the count by one. Word contents and ordering are outside what the checker sees. These include the newer/older half placement in mono packing, the swap order in stereo, sign extension, and the held half-word that a flush drops. Only the bench scenarios, compared against a queue model, can show them. The same holds for the strict-versus-equal threshold boundary, which the bench checks as a read value.

// File: rtl/pcm_pack_pkg.sv
package pcm_pack_pkg;
  localparam logic [2:0] ADDR_DATA     = 3'd0;
  localparam logic [2:0] ADDR_COUNT    = 3'd1;
  localparam logic [2:0] ADDR_FLUSH    = 3'd2;
  localparam logic [2:0] ADDR_THRESH   = 3'd3;
  localparam logic [2:0] ADDR_IRQ_EN   = 3'd4;
  localparam logic [2:0] ADDR_IRQ_STAT = 3'd5;
  localparam logic [2:0] ADDR_IRQ_SET  = 3'd6;
  localparam logic [2:0] ADDR_IRQ_CLR  = 3'd7;

  localparam int IRQ_N   = 3;
  localparam int IRQ_THR = 0;
  localparam int IRQ_OVF = 1;
  localparam int IRQ_UDF = 2;

  localparam logic [1:0] CH_LEFT  = 2'd0;
  localparam logic [1:0] CH_RIGHT = 2'd1;
endpackage

// File: rtl/pcm_packer.sv
module pcm_packer #(
  parameter int SAMPLE_W = 16,
  localparam int WORD_W  = 2 * SAMPLE_W
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                frame_valid_i,
  input  logic [SAMPLE_W-1:0] left_i,
  input  logic [SAMPLE_W-1:0] right_i,
  input  logic [1:0]          chan_sel_i,
  input  logic                swap_i,
  input  logic                pack_i,
  input  logic                flush_i,
  output logic [1:0]          n_o,
  output logic [WORD_W-1:0]   w0_o,
  output logic [WORD_W-1:0]   w1_o
);
  import pcm_pack_pkg::*;

  logic [SAMPLE_W-1:0] hold_q, first_s, second_s, mono_s;
  logic                hold_vld_q, stereo;

  function automatic logic [WORD_W-1:0] sext(input logic [SAMPLE_W-1:0] s);
    return {{(WORD_W-SAMPLE_W){s[SAMPLE_W-1]}}, s};
  endfunction

  assign stereo   = chan_sel_i[1];
  assign first_s  = swap_i ? right_i : left_i;
  assign second_s = swap_i ? left_i  : right_i;
  assign mono_s   = (chan_sel_i == CH_RIGHT) ? right_i : left_i;

  always_comb begin
    n_o  = 2'd0;
    w0_o = '0;
    w1_o = '0;
    if (frame_valid_i && !flush_i) begin
      if (stereo) begin
        if (pack_i) begin
          n_o  = 2'd1;
          w0_o = {first_s, second_s};
        end else begin
          n_o  = 2'd2;
          w0_o = sext(first_s);
          w1_o = sext(second_s);
        end
      end else if (pack_i) begin
        if (hold_vld_q) begin
          n_o  = 2'd1;
          w0_o = {mono_s, hold_q};
        end
      end else begin
        n_o  = 2'd1;
        w0_o = sext(mono_s);
      end
    end
  end

  // half-word held until its partner arrives in packed mono
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_q     <= '0;
      hold_vld_q <= 1'b0;
    end else if (flush_i) begin
      hold_vld_q <= 1'b0;
    end else if (frame_valid_i && !stereo && pack_i) begin
      hold_q     <= mono_s;
      hold_vld_q <= !hold_vld_q;
    end
  end
endmodule

// File: rtl/pcm_word_fifo.sv
module pcm_word_fifo #(
  parameter int WORD_W = 32,
  parameter int DEPTH  = 8,
  localparam int AW    = $clog2(DEPTH),
  localparam int CW    = AW + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [1:0]        n_push_i,
  input  logic [WORD_W-1:0] w0_i,
  input  logic [WORD_W-1:0] w1_i,
  input  logic              pop_i,
  input  logic              flush_i,
  output logic [WORD_W-1:0] head_o,
  output logic [CW-1:0]     count_o,
  output logic              ovf_o,
  output logic              udf_o
);
  localparam logic [CW-1:0] DEPTH_C = CW'(DEPTH);

  logic [WORD_W-1:0] mem [DEPTH];
  logic [AW-1:0]     wptr_q, rptr_q;
  logic [CW-1:0]     cnt_q, free_s, n_req, n_acc;
  logic              pop_ok;

  assign free_s  = DEPTH_C - cnt_q;
  assign n_req   = CW'(n_push_i);
  assign ovf_o   = n_req > free_s;
  assign n_acc   = ovf_o ? free_s : n_req;
  assign pop_ok  = pop_i && (cnt_q != '0);
  assign udf_o   = pop_i && (cnt_q == '0);
  assign count_o = cnt_q;
  assign head_o  = (cnt_q == '0) ? '0 : mem[rptr_q];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wptr_q <= '0;
      rptr_q <= '0;
      cnt_q  <= '0;
    end else if (flush_i) begin
      wptr_q <= '0;
      rptr_q <= '0;
      cnt_q  <= '0;
    end else begin
      wptr_q <= wptr_q + AW'(n_acc);
      rptr_q <= rptr_q + AW'(pop_ok);
      cnt_q  <= cnt_q + n_acc - CW'(pop_ok);
    end
  end

  always_ff @(posedge clk_i) begin
    if (!flush_i) begin
      if (n_acc != '0) mem[wptr_q] <= w0_i;
      if (n_acc == CW'(2)) mem[wptr_q + AW'(1)] <= w1_i;
    end
  end
endmodule

// File: rtl/pcm_irq_ctrl.sv
module pcm_irq_ctrl #(
  parameter int N = 3
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] event_i,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  input  logic         en_we_i,
  input  logic [N-1:0] en_wdata_i,
  output logic [N-1:0] stat_o,
  output logic [N-1:0] en_o,
  output logic         irq_o
);
  logic [N-1:0] stat_q, en_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stat_q <= '0;
      en_q   <= '0;
    end else begin
      stat_q <= (stat_q & ~clr_i) | set_i | event_i;
      if (en_we_i) en_q <= en_wdata_i;
    end
  end

  assign stat_o = stat_q;
  assign en_o   = en_q;
  assign irq_o  = |(stat_q & en_q);
endmodule

// File: rtl/pcm_pack_fifo.sv
module pcm_pack_fifo #(
  parameter int SAMPLE_W = 16,
  parameter int DEPTH    = 8,
  localparam int WORD_W  = 2 * SAMPLE_W,
  localparam int CW      = $clog2(DEPTH) + 1
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                frame_valid_i,
  input  logic [SAMPLE_W-1:0] left_i,
  input  logic [SAMPLE_W-1:0] right_i,
  input  logic [1:0]          chan_sel_i,
  input  logic                swap_i,
  input  logic                pack_i,
  input  logic                reg_we_i,
  input  logic                reg_re_i,
  input  logic [2:0]          reg_addr_i,
  input  logic [WORD_W-1:0]   reg_wdata_i,
  output logic [WORD_W-1:0]   reg_rdata_o,
  output logic                irq_o
);
  import pcm_pack_pkg::*;

  logic [1:0]        n_push;
  logic [WORD_W-1:0] w0, w1, head;
  logic [CW-1:0]     cnt, thresh_q;
  logic              flush, pop, ovf, udf;
  logic [IRQ_N-1:0]  evt, set_v, clr_v, stat, en;

  assign flush = reg_we_i && (reg_addr_i == ADDR_FLUSH);
  assign pop   = reg_re_i && (reg_addr_i == ADDR_DATA);
  assign set_v = (reg_we_i && reg_addr_i == ADDR_IRQ_SET) ? reg_wdata_i[IRQ_N-1:0] : '0;
  assign clr_v = (reg_we_i && reg_addr_i == ADDR_IRQ_CLR) ? reg_wdata_i[IRQ_N-1:0] : '0;

  always_comb begin
    evt          = '0;
    evt[IRQ_THR] = cnt > thresh_q;
    evt[IRQ_OVF] = ovf;
    evt[IRQ_UDF] = udf;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                      thresh_q <= '0;
    else if (reg_we_i && reg_addr_i == ADDR_THRESH)   thresh_q <= reg_wdata_i[CW-1:0];
  end

  pcm_packer #(.SAMPLE_W(SAMPLE_W)) u_packer (
    .clk_i, .rst_ni, .frame_valid_i, .left_i, .right_i,
    .chan_sel_i, .swap_i, .pack_i,
    .flush_i(flush), .n_o(n_push), .w0_o(w0), .w1_o(w1)
  );

  pcm_word_fifo #(.WORD_W(WORD_W), .DEPTH(DEPTH)) u_fifo (
    .clk_i, .rst_ni, .n_push_i(n_push), .w0_i(w0), .w1_i(w1),
    .pop_i(pop), .flush_i(flush), .head_o(head), .count_o(cnt),
    .ovf_o(ovf), .udf_o(udf)
  );

  pcm_irq_ctrl #(.N(IRQ_N)) u_irq (
    .clk_i, .rst_ni, .event_i(evt), .set_i(set_v), .clr_i(clr_v),
    .en_we_i(reg_we_i && reg_addr_i == ADDR_IRQ_EN),
    .en_wdata_i(reg_wdata_i[IRQ_N-1:0]),
    .stat_o(stat), .en_o(en), .irq_o
  );

  always_comb begin
    reg_rdata_o = '0;
    unique case (reg_addr_i)
      ADDR_DATA:     reg_rdata_o = head;
      ADDR_COUNT:    reg_rdata_o = WORD_W'(cnt);
      ADDR_THRESH:   reg_rdata_o = WORD_W'(thresh_q);
      ADDR_IRQ_EN:   reg_rdata_o = WORD_W'(en);
      ADDR_IRQ_STAT: reg_rdata_o = WORD_W'(stat);
      default:       reg_rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/pcm_pack_fifo_chk.sv
module pcm_pack_fifo_chk #(
  parameter int DEPTH = 8,
  parameter int CW    = 4
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic [CW-1:0] cnt,
  input logic [CW-1:0] thresh_q,
  input logic [2:0]    stat,
  input logic [1:0]    n_push,
  input logic          flush,
  input logic          pop,
  input logic          ovf
);
  // R5
  count_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt <= CW'(DEPTH));
  // R5
  pop_dec_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop && cnt != '0 && n_push == 2'd0 && !flush) |=> cnt == $past(cnt) - CW'(1));
  // R6
  flush_empty_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush |=> cnt == '0);
  // R7
  thr_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt > thresh_q) |=> stat[0]);
  // R8
  ovf_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf |=> stat[1]);
  // R9
  udf_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop && cnt == '0) |=> stat[2]);
endmodule

bind pcm_pack_fifo pcm_pack_fifo_chk #(.DEPTH(DEPTH), .CW(CW)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .cnt(cnt), .thresh_q(thresh_q), .stat(stat),
  .n_push(n_push), .flush(flush), .pop(pop), .ovf(ovf)
);

// File: tb/tb_pcm_pack_fifo.sv
`timescale 1ns/1ps
module tb_pcm_pack_fifo;
  localparam int DEPTH = 8;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic        rst_ni, frame_valid, swap, pack, we, re, irq;
  logic [15:0] left, right;
  logic [1:0]  chan;
  logic [2:0]  addr;
  logic [31:0] wdata, rdata;

  pcm_pack_fifo #(.SAMPLE_W(16), .DEPTH(DEPTH)) dut (
    .clk_i(clk), .rst_ni, .frame_valid_i(frame_valid), .left_i(left), .right_i(right),
    .chan_sel_i(chan), .swap_i(swap), .pack_i(pack), .reg_we_i(we), .reg_re_i(re),
    .reg_addr_i(addr), .reg_wdata_i(wdata), .reg_rdata_o(rdata), .irq_o(irq)
  );

  int    n_chk = 0, n_fail = 0;
  string req = "R1";

  logic [31:0] mq[$];
  logic [15:0] m_hold;
  bit          m_hv;
  logic [2:0]  m_stat, m_en;
  int          m_thr;

  function automatic logic [31:0] sx(input logic [15:0] s);
    return {{16{s[15]}}, s};
  endfunction

  function automatic logic [31:0] m_rdata(input logic [2:0] a);
    case (a)
      3'd0: return (mq.size() == 0) ? 32'h0 : mq[0];
      3'd1: return 32'(mq.size());
      3'd3: return 32'(m_thr);
      3'd4: return 32'(m_en);
      3'd5: return 32'(m_stat);
      default: return 32'h0;
    endcase
  endfunction

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_update();
    logic [31:0] w[$];
    int pre = mq.size();
    bit fl  = we && addr == 3'd2;
    bit rd  = re && addr == 3'd0;
    bit thr = pre > m_thr;
    bit ovf = 0, udf = 0;
    logic [2:0] ws = 0, wc = 0;
    if (frame_valid && !fl) begin
      logic [15:0] f = swap ? right : left;
      logic [15:0] s = swap ? left : right;
      logic [15:0] m = (chan == 2'd1) ? right : left;
      if (chan[1]) begin
        if (pack) w.push_back({f, s});
        else begin w.push_back(sx(f)); w.push_back(sx(s)); end
      end else if (pack) begin
        if (m_hv) begin w.push_back({m, m_hold}); m_hv = 0; end
        else begin m_hold = m; m_hv = 1; end
      end else w.push_back(sx(m));
    end
    if (rd) begin
      if (pre == 0) udf = 1;
      else void'(mq.pop_front());
    end
    foreach (w[i]) begin
      if (i < DEPTH - pre) mq.push_back(w[i]);
      else ovf = 1;
    end
    if (fl) begin mq.delete(); m_hv = 0; end
    if (we && addr == 3'd6) ws = wdata[2:0];
    if (we && addr == 3'd7) wc = wdata[2:0];
    if (we && addr == 3'd4) m_en = wdata[2:0];
    if (we && addr == 3'd3) m_thr = int'(wdata[3:0]);
    m_stat = (m_stat & ~wc) | ws | {udf, ovf, thr};
  endtask

  task automatic tick();
    #0.5;
    chk(rdata, m_rdata(addr), req);
    chk({31'h0, irq}, {31'h0, |(m_stat & m_en)}, "R10 irq");
    @(posedge clk);
    model_update();
    @(negedge clk);
    frame_valid = 0; we = 0; re = 0; addr = 3'd1; wdata = 0;
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    addr = a; wdata = d; we = 1; tick();
  endtask

  task automatic frame(input logic [15:0] l, input logic [15:0] r);
    frame_valid = 1; left = l; right = r; tick();
  endtask

  task automatic pop_exp(input logic [31:0] exp, input string tag);
    addr = 3'd0; re = 1; #0.5;
    chk(rdata, exp, tag);
    tick();
  endtask

  task automatic peek(input logic [2:0] a, input logic [31:0] exp, input string tag);
    addr = a; #0.5;
    chk(rdata, exp, tag);
    tick();
  endtask

  task automatic cfg(input logic [1:0] c, input logic s, input logic p);
    chan = c; swap = s; pack = p; wr(3'd2, 32'h0);
  endtask

  bit done = 0;
  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    rst_ni = 0; frame_valid = 0; swap = 0; pack = 0; we = 0; re = 0;
    left = 0; right = 0; chan = 0; addr = 3'd1; wdata = 0;
    m_hv = 0; m_hold = 0; m_stat = 0; m_en = 0; m_thr = 0;
    repeat (3) @(negedge clk);
    rst_ni = 1;

    req = "R1";
    peek(3'd1, 32'h0, "R1 count");
    peek(3'd3, 32'h0, "R1 thresh");
    peek(3'd4, 32'h0, "R1 enable");
    peek(3'd5, 32'h0, "R1 status");
    chk({31'h0, irq}, 32'h0, "R1 irq");

    wr(3'd3, 32'd7);

    req = "R2";
    cfg(2'd0, 1'b0, 1'b1);
    frame(16'h0001, 16'hAAAA); frame(16'h0002, 16'hBBBB);
    frame(16'h0003, 16'hCCCC); frame(16'h0004, 16'hDDDD);
    peek(3'd1, 32'd2, "R5 count after two pairs");
    pop_exp(32'h0002_0001, "R2 mono-left newer high");
    pop_exp(32'h0004_0003, "R2 mono-left second word");
    cfg(2'd1, 1'b1, 1'b1);
    frame(16'hAAAA, 16'h0005); frame(16'hBBBB, 16'h0006);
    pop_exp(32'h0006_0005, "R2 mono-right, swap ignored");

    req = "R3";
    cfg(2'd2, 1'b0, 1'b1);
    frame(16'h1234, 16'h5678);
    swap = 1; frame(16'h1234, 16'h5678);
    pop_exp(32'h1234_5678, "R3 stereo left high");
    pop_exp(32'h5678_1234, "R3 stereo swapped");

    req = "R4";
    cfg(2'd3, 1'b1, 1'b0);
    frame(16'h8001, 16'h0002);
    peek(3'd1, 32'd2, "R4 two words per frame");
    pop_exp(32'h0000_0002, "R4 swap right first");
    pop_exp(32'hFFFF_8001, "R4 sign extend left");
    cfg(2'd0, 1'b1, 1'b0);
    frame(16'hFFFE, 16'h0003);
    pop_exp(32'hFFFF_FFFE, "R4 mono-left unpacked");

    req = "R9";
    wr(3'd4, 32'h7);
    wr(3'd7, 32'h7);
    pop_exp(32'h0, "R9 empty read returns zero");
    peek(3'd5, 32'h4, "R9 underflow status");
    chk({31'h0, irq}, 32'h1, "R10 irq from underflow");

    req = "R6";
    cfg(2'd0, 1'b0, 1'b1);
    frame(16'h0009, 16'h0);
    wr(3'd2, 32'hDEAD_BEEF);
    frame(16'h000A, 16'h0); frame(16'h000B, 16'h0);
    frame_valid = 1; left = 16'h00CC; wr(3'd2, 32'h0);
    peek(3'd1, 32'd0, "R6 flush wins over frame");
    frame(16'h000A, 16'h0); frame(16'h000B, 16'h0);
    pop_exp(32'h000B_000A, "R6 held half dropped");

    req = "R7";
    wr(3'd3, 32'd3);
    cfg(2'd0, 1'b0, 1'b0);
    frame(16'd1, 16'd0); frame(16'd2, 16'd0); frame(16'd3, 16'd0);
    wr(3'd7, 32'h7);
    peek(3'd5, 32'h0, "R7 equal count does not set");
    frame(16'd4, 16'd0);
    wr(3'd7, 32'h0);
    peek(3'd5, 32'h1, "R7 count above threshold sets");
    wr(3'd7, 32'h1);
    peek(3'd5, 32'h1, "R10 event wins over clear");

    req = "R8";
    cfg(2'd2, 1'b0, 1'b0);
    wr(3'd7, 32'h7);
    frame(16'd1, 16'd2); frame(16'd3, 16'd4); frame(16'd5, 16'd6);
    frame(16'd7, 16'd8); frame(16'd9, 16'd10);
    peek(3'd1, 32'd8, "R8 count saturates at depth");
    peek(3'd5, 32'h3, "R8 overflow status");
    addr = 3'd0; re = 1; frame_valid = 1; left = 16'd11; right = 16'd12; tick();
    peek(3'd1, 32'd7, "R8 pop does not free space same edge");
    pop_exp(32'd2, "R8 oldest kept word");

    req = "R10";
    wr(3'd2, 32'h0);
    wr(3'd3, 32'd15);
    wr(3'd7, 32'h7);
    wr(3'd4, 32'h2);
    wr(3'd6, 32'h5);
    peek(3'd5, 32'h5, "R10 write-one-to-set");
    chk({31'h0, irq}, 32'h0, "R10 masked sources");
    wr(3'd6, 32'h2);
    chk({31'h0, irq}, 32'h1, "R10 enabled source");
    wr(3'd7, 32'h3);
    peek(3'd5, 32'h4, "R10 write-one-to-clear");
    peek(3'd4, 32'h2, "R10 enable readback");

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule